// File: doc/BRIEF.md
# Mode-Multiplexed Address/GPIO Port

This block controls an eight-pin bidirectional port. The pins can carry the upper byte of an external address bus, or they can act as general-purpose pins. The role of each pin comes from a 3-bit operating-mode input together with that pin's bit in a direction register. In the bus-only modes (1 and 3), every pin drives its address bit. In the mixed modes (5 and 6), the direction bit decides whether a pin drives its address bit or is an input. In single-chip mode (7), the pins are plain I/O: a driven pin carries its bit from the data register.

A small register interface writes the data register and the direction register. When a pin is an input, its data-register bit also serves as its pull-up enable. A read of the data select returns the pin levels, or the latched data for pins driven in single-chip mode. The pad driver takes the per-pin output-enable, output-value and pull-up-enable outputs. All three are registered, so the pads see clean edges.

Top module: `addr_gpio_port`

## Requirements
- R1: Pin n carries address bit 8+n. Input `bus_addr_hi` bit n is A(8+n), so when pin n drives an address, `pin_out[n]` equals `bus_addr_hi[n]` (pin 7 is A15, pin 0 is A8).
- R2: In modes 1 and 3, every pin has `pin_oe`=1 and drives the address byte, whatever the direction register holds.
- R3: In modes 5 and 6, a pin whose direction bit is 1 drives its address bit. A pin whose direction bit is 0 has `pin_oe`=0.
- R4: In mode 7, a pin whose direction bit is 1 drives its data-register bit. A pin whose direction bit is 0 has `pin_oe`=0.
- R5: `pin_pu[n]` is 1 exactly when pin n is an input (direction bit 0 in mode 5, 6 or 7) and its data-register bit is 1. Pull-ups are never on in modes 1 and 3.
- R6: With `reg_sel`=0, `reg_rdata[n]` returns the data-register bit when pin n is a mode-7 output. In every other case it returns `pin_in[n]`.
- R7: Mode values 0, 2 and 4 behave exactly like mode 7.
- R8: `reg_we` with `reg_sel`=1 writes the direction register. `reg_we` with `reg_sel`=0 writes the data register. With `reg_sel`=1, `reg_rdata` always reads 8'hFF.
- R9: Synchronous reset clears the direction and data registers, and clears `pin_oe`, `pin_out` and `pin_pu` to 0.
- R10: The pin outputs are registered. A change of `mode` or `bus_addr_hi` appears after the next clock edge. A register written at edge k affects the pins after edge k+1.
- R11: A pin that is not driven has `pin_out`=0 and is never driven while its pull-up is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operating mode |
| bus_addr_hi | input | 8 | Upper address byte, bit n = A(8+n) |
| reg_sel | input | 1 | 0 = data register / port, 1 = direction register |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| pin_in | input | 8 | Pin levels from the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin pull-up enable |

## Verification
The assertions check on every cycle that the bus-only modes force the address onto every pin, and that the mixed modes follow the direction bits. They also check that undriven pins stay low, that a pull-up never overlaps a drive, that the direction select reads all ones, and that reset clears the outputs. Only the bench's scenarios can show some other behaviours. These include the one-cycle gap between a register write and the pins, the aliasing of modes 0, 2 and 4 to single-chip behaviour, and the read mux choosing between latched data and pin level. The bench shows them by comparing against a behavioural model across mode sweeps and random traffic.

// File: rtl/addr_gpio_pkg.sv
package addr_gpio_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        MC_BUS_ONLY  = 2'd0,
        MC_BUS_MIXED = 2'd1,
        MC_SINGLE    = 2'd2
    } mode_class_e;

    typedef enum logic [1:0] {
        ROLE_IN   = 2'd0,
        ROLE_ADDR = 2'd1,
        ROLE_OUT  = 2'd2
    } pin_role_e;

    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
    } pin_drive_t;

    function automatic mode_class_e classify_mode(input logic [MODE_W-1:0] m);
        case (m)
            3'd1, 3'd3: classify_mode = MC_BUS_ONLY;
            3'd5, 3'd6: classify_mode = MC_BUS_MIXED;
            default:    classify_mode = MC_SINGLE;   // R7: 0,2,4,7
        endcase
    endfunction

    function automatic pin_drive_t drive_for_role(input pin_role_e r,
                                                  input logic addr_bit,
                                                  input logic data_bit);
        pin_drive_t d;
        d = '0;
        case (r)
            ROLE_ADDR: begin d.oe = 1'b1; d.out = addr_bit; end
            ROLE_OUT:  begin d.oe = 1'b1; d.out = data_bit; end
            default:   d.pu = data_bit;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/agp_regs.sv
module agp_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_sel,
    input  logic             reg_we,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            data_q <= '0;
        end else if (reg_we) begin
            if (reg_sel) dir_q  <= reg_wdata;
            else         data_q <= reg_wdata;
        end
    end

    a_r9_regs_cleared: assert property (@(posedge clk)
        rst |=> (dir_q == '0 && data_q == '0));
endmodule

// File: rtl/agp_role_decode.sv
module agp_role_decode
    import addr_gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  mode_class_e      mclass,
    input  logic [WIDTH-1:0] dir_q,
    output pin_role_e        role [WIDTH]
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_role
        always_comb begin
            case (mclass)
                MC_BUS_ONLY:  role[i] = ROLE_ADDR;
                MC_BUS_MIXED: role[i] = dir_q[i] ? ROLE_ADDR : ROLE_IN;
                default:      role[i] = dir_q[i] ? ROLE_OUT  : ROLE_IN;
            endcase
        end
    end
endmodule

// File: rtl/agp_drive.sv
module agp_drive
    import addr_gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  pin_role_e        role [WIDTH],
    input  logic [WIDTH-1:0] addr_byte,
    input  logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        pin_drive_t nxt;
        always_comb nxt = drive_for_role(role[i], addr_byte[i], data_q[i]);

        always_ff @(posedge clk) begin
            if (rst) begin
                pin_oe[i]  <= 1'b0;
                pin_out[i] <= 1'b0;
                pin_pu[i]  <= 1'b0;
            end else begin
                pin_oe[i]  <= nxt.oe;
                pin_out[i] <= nxt.out;
                pin_pu[i]  <= nxt.pu;
            end
        end
    end

    a_r11_undriven_low: assert property (@(posedge clk) disable iff (rst)
        ((pin_out & ~pin_oe) == '0));
    a_r11_pu_not_driven: assert property (@(posedge clk) disable iff (rst)
        ((pin_pu & pin_oe) == '0));
    a_r9_outputs_cleared: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0 && pin_pu == '0));
endmodule

// File: rtl/addr_gpio_port.sv
module addr_gpio_port
    import addr_gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic [WIDTH-1:0]  bus_addr_hi,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [WIDTH-1:0]  reg_wdata,
    output logic [WIDTH-1:0]  reg_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_pu
);
    localparam logic [WIDTH-1:0] DIR_READ_VALUE = '1;

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] data_q;
    mode_class_e      mclass;
    pin_role_e        role [WIDTH];
    logic [WIDTH-1:0] port_view;

    always_comb mclass = classify_mode(mode);

    agp_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .dir_q     (dir_q),
        .data_q    (data_q)
    );

    agp_role_decode #(.WIDTH(WIDTH)) u_decode (
        .mclass (mclass),
        .dir_q  (dir_q),
        .role   (role)
    );

    agp_drive #(.WIDTH(WIDTH)) u_drive (
        .clk       (clk),
        .rst       (rst),
        .role      (role),
        .addr_byte (bus_addr_hi),
        .data_q    (data_q),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out),
        .pin_pu    (pin_pu)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_rd
        always_comb port_view[i] = (role[i] == ROLE_OUT) ? data_q[i] : pin_in[i];
    end

    always_comb reg_rdata = reg_sel ? DIR_READ_VALUE : port_view;

    a_r2_bus_only_drives_addr: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd1 || mode == 3'd3) |=>
            (pin_oe == '1 && pin_out == $past(bus_addr_hi) && pin_pu == '0));
    a_r3_mixed_follows_dir: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd5 || mode == 3'd6) |=>
            (pin_oe == $past(dir_q) && pin_out == ($past(bus_addr_hi) & $past(dir_q))));
    a_r8_dir_reads_ones: assert property (@(posedge clk) disable iff (rst)
        reg_sel |-> (reg_rdata == DIR_READ_VALUE));
endmodule

// File: tb/addr_gpio_port_tb.sv
module addr_gpio_port_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] mode;
    logic [7:0] bus_addr_hi;
    logic       reg_sel;
    logic       reg_we;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [7:0] pin_in;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;
    logic [7:0] pin_pu;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    addr_gpio_port u_dut (
        .clk(clk), .rst(rst), .mode(mode), .bus_addr_hi(bus_addr_hi),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .pin_pu(pin_pu)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_dir, m_data;
    logic [7:0] e_oe, e_out, e_pu;

    function automatic int kind_of(input logic [2:0] m);
        if (m == 3'd1 || m == 3'd3) return 0;        // bus only
        if (m == 3'd5 || m == 3'd6) return 1;        // mixed
        return 2;                                    // single chip
    endfunction

    function automatic logic [7:0] model_read(input logic sel);
        logic [7:0] r;
        if (sel) return 8'hFF;
        for (int b = 0; b < 8; b++)
            r[b] = (kind_of(mode) == 2 && m_dir[b]) ? m_data[b] : pin_in[b];
        return r;
    endfunction

    always @(posedge clk) begin
        logic [7:0] oe, ov, pu;
        if (rst) begin
            m_dir <= 8'h00; m_data <= 8'h00;
            e_oe <= 8'h00; e_out <= 8'h00; e_pu <= 8'h00;
        end else begin
            for (int b = 0; b < 8; b++) begin
                case (kind_of(mode))
                    0: begin oe[b] = 1'b1; ov[b] = bus_addr_hi[b]; pu[b] = 1'b0; end
                    1: begin oe[b] = m_dir[b]; ov[b] = m_dir[b] & bus_addr_hi[b];
                             pu[b] = ~m_dir[b] & m_data[b]; end
                    default: begin oe[b] = m_dir[b]; ov[b] = m_dir[b] & m_data[b];
                                   pu[b] = ~m_dir[b] & m_data[b]; end
                endcase
            end
            e_oe <= oe; e_out <= ov; e_pu <= pu;
            if (reg_we) begin
                if (reg_sel) m_dir <= reg_wdata;
                else         m_data <= reg_wdata;
            end
        end
    end

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check8("R1/R2/R3/R4/R7 pin_oe", pin_oe, e_oe);
            check8("R1/R2/R3/R4/R11 pin_out", pin_out, e_out);
            check8("R5 pin_pu", pin_pu, e_pu);
            check8("R6/R8 reg_rdata", reg_rdata, model_read(reg_sel));
        end
    end

    task automatic write_reg(input logic sel, input logic [7:0] v);
        @(posedge clk); #1;
        reg_sel = sel; reg_we = 1'b1; reg_wdata = v;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; mode = 3'd7; bus_addr_hi = 8'h00; reg_sel = 1'b0;
        reg_we = 1'b0; reg_wdata = 8'h00; pin_in = 8'h3C;
        idle(3);
        @(negedge clk);
        check8("R9 reset pin_oe", pin_oe, 8'h00);
        check8("R9 reset pin_pu", pin_pu, 8'h00);
        check8("R9 reset read", reg_rdata, 8'h3C);
        @(posedge clk); #1;
        rst = 1'b0;

        // R10: write at edge k, pins move after edge k+1
        write_reg(1'b1, 8'hF0);
        @(negedge clk);
        check8("R10 oe before latency", pin_oe, 8'h00);
        @(negedge clk);
        check8("R10 oe after latency", pin_oe, 8'hF0);
        write_reg(1'b0, 8'hA5);
        idle(2);
        @(negedge clk);
        check8("R4 mode7 pin_out", pin_out, 8'hA0);
        check8("R5 mode7 pull-ups", pin_pu, 8'h05);
        pin_in = 8'h0F;
        #1;
        check8("R6 mode7 read mix", reg_rdata, 8'hAF);
        reg_sel = 1'b1; #1;
        check8("R8 dir read ones", reg_rdata, 8'hFF);
        reg_sel = 1'b0;

        // R1/R2: bus-only modes ignore direction
        @(posedge clk); #1;
        mode = 3'd3; bus_addr_hi = 8'h80;
        idle(1);
        @(negedge clk);
        check8("R1 pin7 is A15", pin_out, 8'h80);
        check8("R2 all driven", pin_oe, 8'hFF);
        check8("R5 no pull-up in bus mode", pin_pu, 8'h00);
        check8("R6 bus read pin level", reg_rdata, 8'h0F);

        // R3: mixed mode
        @(posedge clk); #1;
        mode = 3'd5; bus_addr_hi = 8'h5A;
        idle(1);
        @(negedge clk);
        check8("R3 mixed oe", pin_oe, 8'hF0);
        check8("R3 mixed out", pin_out, 8'h50);

        // R7: mode 0 behaves as 7
        @(posedge clk); #1;
        mode = 3'd0;
        idle(1);
        @(negedge clk);
        check8("R7 mode0 out as mode7", pin_out, 8'hA0);

        // sweep every mode with several patterns
        for (int m = 0; m < 8; m++) begin
            @(posedge clk); #1;
            mode = 3'(m);
            write_reg(1'b1, 8'(8'h3C ^ (m * 17)));
            write_reg(1'b0, 8'(8'hC3 + m));
            bus_addr_hi = 8'(m * 29);
            idle(3);
        end

        // random traffic
        for (int n = 0; n < 400; n++) begin
            @(posedge clk); #1;
            mode        = 3'($urandom_range(0, 7));
            bus_addr_hi = 8'($urandom);
            pin_in      = 8'($urandom);
            reg_sel     = 1'($urandom);
            reg_we      = ($urandom_range(0, 3) == 0);
            reg_wdata   = 8'($urandom);
        end
        @(posedge clk); #1;
        reg_we = 1'b0;
        idle(3);

        // mid-run reset
        rst = 1'b1;
        idle(1);
        @(negedge clk);
        check8("R9 re-reset oe", pin_oe, 8'h00);
        @(posedge clk); #1;
        rst = 1'b0;
        idle(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule